// File: doc/BRIEF.md
# Interlocked Read-Bus Memory Responder

This block is the memory end of a fully interlocked, clockless read bus. A requester places a word address on the shared data lines and raises its request strobe. The responder captures the address, acknowledges, and starts a deliberately slow internal read. It then completes the read-back half of the exchange. It raises a ready strobe with the word on the data lines, and it releases both when the requester acknowledges the word.

The internal read is timed by a cycle counter that stands in for a slow DRAM access. The counter starts when the address is captured, so it runs while the requester withdraws its request and the responder withdraws its acknowledge. A transfer therefore costs the larger of the access time and those handshake steps, not their sum. Both incoming strobes pass through two-flop synchronizers before the controller acts on them. The data lines are modelled as separate input, output and output-enable ports.

Top module: `mem_responder`

## Requirements
- R1: While reset is held and after it is released, `ack_o`, `data_rdy_o` and `bus_oe_o` are low and `bus_o` is zero.
- R2: When the synchronized `read_req_i` is seen high in idle, the full 32-bit value on `bus_i` is captured as the word address and `ack_o` rises.
- R3: `ack_o` falls only after the synchronized `read_req_i` is seen low. While the request stays high, `ack_o` stays high.
- R4: When the read completes, the word is presented on `bus_o` with `bus_oe_o` high and `data_rdy_o` high, and it stays stable while `data_rdy_o` is high.
- R5: When the synchronized `ack_i` is seen high, `data_rdy_o` and `bus_oe_o` both fall.
- R6: The word at index `a` for `a < WORDS` is `(a * 32'h9E3779B1) ^ 32'hC3A50000` in 32-bit arithmetic. An address of `WORDS` or more reads as zero.
- R7: `data_rdy_o` never rises earlier than `ACCESS_CYC + 1` cycles after `ack_o` rises, and never while `ack_o` is high. The default `ACCESS_CYC` is 25, which is 200 ns at an 8 ns clock.
- R8: The access overlaps the request release. If the requester drops its request promptly, `data_rdy_o` rises exactly `ACCESS_CYC + 1` cycles after `ack_o` rises. If it holds the request past the access, `data_rdy_o` rises one cycle after `ack_o` falls.
- R9: After `data_rdy_o` falls, a new request is ignored, with `ack_o` held low, until the synchronized `ack_i` has returned low. The pending request is then served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| read_req_i | input | 1 | Requester's read request strobe (asynchronous) |
| ack_i | input | 1 | Requester's acknowledge of the returned word (asynchronous) |
| bus_i | input | 32 | Shared data lines as seen by the responder (address phase) |
| bus_o | output | 32 | Word driven onto the shared data lines |
| bus_oe_o | output | 1 | Output enable for `bus_o` |
| ack_o | output | 1 | Responder's acknowledge of the request |
| data_rdy_o | output | 1 | Read word is valid on the data lines |

## Verification
The assertions assume that the requester keeps the full interlock. It holds the address steady while its request is high until it has seen `ack_o`. It raises `ack_i` only while `data_rdy_o` is high, and it does not drop `ack_i` until it has seen `data_rdy_o` low. The bench's requester tasks wait on each responder strobe before moving the next edge. They scramble `bus_i` only after the request is withdrawn. Randomized hold times and addresses, including addresses past the array, vary only within that protocol.

// File: rtl/mem_responder_pkg.sv
package mem_responder_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACK   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DRIVE = 3'd3,
    ST_DONE  = 3'd4
  } resp_state_e;

  function automatic logic [31:0] word_pattern(input logic [31:0] idx);
    word_pattern = (idx * 32'h9E3779B1) ^ 32'hC3A50000;
  endfunction

endpackage

// File: rtl/resp_sync2.sv
module resp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/resp_access_timer.sv
module resp_access_timer #(
  parameter int ACCESS_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    done_d = done_q;
    if (start_i) begin
      cnt_d  = CNT_LOAD;
      done_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_ONE;
      done_d = (cnt_q == CNT_ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  assert_done_after_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(cnt_q) == CNT_ONE))
    else $error("access finished without counting down");
endmodule

// File: rtl/resp_word_store.sv
module resp_word_store #(
  parameter int WORDS = 64
) (
  input  logic [31:0] addr_i,
  output logic [31:0] word_o
);
  import mem_responder_pkg::*;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0] rom [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign rom[g] = word_pattern(32'(g));
  end

  logic in_range;
  assign in_range = (addr_i < 32'(WORDS));
  assign word_o   = in_range ? rom[addr_i[IDX_W-1:0]] : 32'h0;
endmodule

// File: rtl/mem_responder.sv
module mem_responder #(
  parameter int WORDS      = 64,
  parameter int ACCESS_CYC = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        read_req_i,
  input  logic        ack_i,
  input  logic [31:0] bus_i,
  output logic [31:0] bus_o,
  output logic        bus_oe_o,
  output logic        ack_o,
  output logic        data_rdy_o
);
  import mem_responder_pkg::*;

  logic        req_s, ack_s;
  logic [1:0]  sync_out;
  resp_state_e state_q, state_d;
  logic [31:0] addr_q, data_q, rd_word;
  logic        start_acc, cap_word, acc_done;

  resp_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({read_req_i, ack_i}),
    .q_o   (sync_out)
  );
  assign req_s = sync_out[1];
  assign ack_s = sync_out[0];

  resp_access_timer #(.ACCESS_CYC(ACCESS_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_acc),
    .done_o  (acc_done)
  );

  resp_word_store #(.WORDS(WORDS)) u_store (
    .addr_i (addr_q),
    .word_o (rd_word)
  );

  always_comb begin
    state_d   = state_q;
    start_acc = 1'b0;
    cap_word  = 1'b0;
    case (state_q)
      ST_IDLE:  if (req_s) begin state_d = ST_ACK; start_acc = 1'b1; end
      ST_ACK:   if (!req_s) state_d = ST_WAIT;
      ST_WAIT:  if (acc_done) begin state_d = ST_DRIVE; cap_word = 1'b1; end
      ST_DRIVE: if (ack_s) state_d = ST_DONE;
      ST_DONE:  if (!ack_s) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (start_acc) addr_q <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (cap_word) data_q <= rd_word;
  end

  assign ack_o      = (state_q == ST_ACK);
  assign data_rdy_o = (state_q == ST_DRIVE);
  assign bus_oe_o   = (state_q == ST_DRIVE);
  assign bus_o      = bus_oe_o ? data_q : 32'h0;

  assert_ack_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s))
    else $error("ack raised without request");

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s))
    else $error("ack dropped while request high");

  assert_word_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rdy_o && $past(data_rdy_o)) |-> $stable(bus_o))
    else $error("word changed while ready");

  assert_release_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy_o) |-> $past(ack_s))
    else $error("ready dropped without requester ack");

  assert_ready_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy_o) |-> $past(acc_done))
    else $error("ready raised before access finished");

  assert_idle_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> !$past(ack_s))
    else $error("new request served while requester ack high");
endmodule

// File: tb/mem_responder_tb.sv
module mem_responder_tb;
  localparam int WORDS = 64;
  localparam int LAT   = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        read_req_i = 1'b0;
  logic        ack_i = 1'b0;
  logic [31:0] bus_i = '0;
  logic [31:0] bus_o;
  logic        bus_oe_o, ack_o, data_rdy_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  mem_responder #(.WORDS(WORDS), .ACCESS_CYC(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .read_req_i(read_req_i), .ack_i(ack_i),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .ack_o(ack_o), .data_rdy_o(data_rdy_o)
  );

  always @(negedge clk) cyc++;

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    if (a < 32'(WORDS)) return (a * 32'h9E3779B1) ^ 32'hC3A50000;
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input logic v);
    int n = 0;
    while (ack_o !== v && n < 1000) begin @(negedge clk); n++; end
  endtask
  task automatic wait_rdy(input logic v);
    int n = 0;
    while (data_rdy_o !== v && n < 1000) begin @(negedge clk); n++; end
  endtask

  // hold = cycles the request stays high after ack_o is seen
  task automatic do_read(input logic [31:0] a, input int hold, input bit chk_fast,
                         input bit chk_slow);
    int t_ack, t_ackfall;
    @(negedge clk);
    bus_i = a; read_req_i = 1'b1;
    wait_ack(1'b1);
    t_ack = cyc;
    check(ack_o === 1'b1, "R2", 32'(ack_o), 32'd1);
    repeat (hold) @(negedge clk);
    check(ack_o === 1'b1, "R3", 32'(ack_o), 32'd1);
    read_req_i = 1'b0; bus_i = $urandom;
    t_ackfall = -1;
    while (data_rdy_o !== 1'b1 && cyc - t_ack < 1000) begin
      if (ack_o === 1'b0 && t_ackfall < 0) t_ackfall = cyc;
      @(negedge clk);
    end
    check(ack_o === 1'b0, "R7", 32'(ack_o), 32'd0);
    check(cyc - t_ack >= LAT + 1, "R7", 32'(cyc - t_ack), 32'(LAT + 1));
    if (chk_fast) check(cyc - t_ack == LAT + 1, "R8", 32'(cyc - t_ack), 32'(LAT + 1));
    if (chk_slow) check(cyc - t_ackfall == 1, "R8", 32'(cyc - t_ackfall), 32'd1);
    check(bus_o === exp_word(a), "R6", bus_o, exp_word(a));
    check(bus_oe_o === 1'b1, "R4", 32'(bus_oe_o), 32'd1);
    @(negedge clk);
    check(data_rdy_o === 1'b1 && bus_o === exp_word(a), "R4", bus_o, exp_word(a));
    ack_i = 1'b1;
    wait_rdy(1'b0);
    check(bus_oe_o === 1'b0 && bus_o === 32'h0, "R5", {31'd0, bus_oe_o}, 32'd0);
    ack_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ack_o === 0 && data_rdy_o === 0 && bus_oe_o === 0 && bus_o === 0,
          "R1", bus_o, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ack_o === 0 && data_rdy_o === 0 && bus_oe_o === 0, "R1",
          {29'd0, ack_o, data_rdy_o, bus_oe_o}, 32'h0);

    // directed: first word, last word, just past the end, far out of range
    do_read(32'd0, 0, 1'b1, 1'b0);
    do_read(32'(WORDS - 1), 0, 1'b1, 1'b0);
    do_read(32'(WORDS), 1, 1'b0, 1'b0);
    do_read(32'hFFFF_FFF0, 0, 1'b1, 1'b0);
    // slow requester: request held beyond the access time
    do_read(32'd17, LAT + 10, 1'b0, 1'b1);

    // R9: new request while requester ack still high is ignored
    begin
      int n;
      @(negedge clk); bus_i = 32'd5; read_req_i = 1'b1;
      wait_ack(1'b1); read_req_i = 1'b0; bus_i = '0;
      wait_rdy(1'b1);
      ack_i = 1'b1;
      wait_rdy(1'b0);
      bus_i = 32'd9; read_req_i = 1'b1;
      n = 0;
      repeat (12) begin @(negedge clk); if (ack_o !== 1'b0) n++; end
      check(n == 0, "R9", 32'(n), 32'd0);
      ack_i = 1'b0;
      wait_ack(1'b1);
      check(ack_o === 1'b1, "R9", 32'(ack_o), 32'd1);
      read_req_i = 1'b0; bus_i = '0;
      wait_rdy(1'b1);
      check(bus_o === exp_word(32'd9), "R9", bus_o, exp_word(32'd9));
      ack_i = 1'b1; wait_rdy(1'b0); ack_i = 1'b0;
      repeat (4) @(negedge clk);
    end

    // random reads
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      int h;
      a = $urandom_range(WORDS + 15, 0);
      h = $urandom_range(3, 0);
      do_read(a, h, (h == 0), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule